// File: doc/BRIEF.md
# Register File with Selectable Write Source

A single-clock storage array of `WORDS` entries, each `WIDTH` bits wide. It has one write port and one read port, each with its own address and its own active-high enable. The data for a write comes from one of two input buses, and a one-bit select line decides which bus is used. Because the two ports have separate addresses, one word can be written while a different word is read in the same cycle.

The read result is registered. It appears one cycle after the edge that samples the read request and stays unchanged while reads are disabled. The parameter `ZERO_WORD` makes entry 0 a constant-zero register: writes to it are accepted but have no effect, and reads of it give all zeros. This is the usual arrangement for a processor register file with a hardwired zero register. The stored words have no reset. Only the read output register is cleared by reset.

Top module: `regfile_dualsrc`

## Requirements
- R1: While `rst_n` is low, `rd_data` is all zeros, and it remains zero after reset is released until the first enabled read.
- R2: On a rising edge with `wr_en` high, the word at `wr_addr` is loaded from `wr_data_a` when `src_sel` is 0 and from `wr_data_b` when `src_sel` is 1.
- R3: On a rising edge with `wr_en` low, no stored word changes.
- R4: On a rising edge with `rd_en` high, `rd_data` takes the word at `rd_addr`, so the result is visible one cycle after the request.
- R5: On a rising edge with `rd_en` low, `rd_data` keeps its previous value.
- R6: When a read and a write address the same word on the same edge, the read returns the contents from before the write.
- R7: A read and a write to different addresses on the same edge both take effect: the read returns the unwritten word and the write lands.
- R8: With `ZERO_WORD` = 1, a write to address 0 leaves the array unchanged and a read of address 0 returns all zeros.
- R9: A write whose address is not below `WORDS` changes no stored word.
- R10: A read whose address is not below `WORDS` returns all zeros.
- R11: The address width is ceil(log2(`WORDS`)) and `WORDS` is at least 2. For example, 6 or 8 words use 3-bit addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for both ports |
| rst_n | input | 1 | Asynchronous active-low clear of the read output register |
| src_sel | input | 1 | Write source: 0 selects `wr_data_a`, 1 selects `wr_data_b` |
| wr_en | input | 1 | Write enable, active high |
| rd_en | input | 1 | Read enable, active high |
| rd_addr | input | AW | Read address |
| wr_addr | input | AW | Write address |
| wr_data_a | input | WIDTH | First write data bus |
| wr_data_b | input | WIDTH | Second write data bus |
| rd_data | output | WIDTH | Registered read data |

## Verification
A write is committed on the edge that samples it. Its effect can only be seen through a read issued on a later edge, and that read's data appears one cycle after its own edge. A read result is therefore due exactly one edge after the request. The bench drives every request at a falling edge, lets one rising edge pass, and compares `rd_data` at the next falling edge with a reference array. That array is updated after the expected read value is taken, which models read-before-write. Two instances share the same stimulus: an 8-word array without the zero register and a 6-word array with it. This exercises both out-of-range addresses and the constant-zero entry.

// File: rtl/regfile_dualsrc.sv
module regfile_dualsrc #(
  parameter int WORDS = 8,
  parameter int WIDTH = 32,
  parameter bit ZERO_WORD = 1'b0,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data_a,
  input  logic [WIDTH-1:0] wr_data_b,
  output logic [WIDTH-1:0] rd_data
);

  localparam logic [AW:0] LIMIT = (AW+1)'(WORDS);

  initial begin
    assert_words_min_R11: assert (WORDS >= 2);
  end

  logic [WIDTH-1:0] mem [WORDS];

  wire [WIDTH-1:0] wdata  = src_sel ? wr_data_b : wr_data_a;
  wire             wr_in  = {1'b0, wr_addr} < LIMIT;
  wire             rd_in  = {1'b0, rd_addr} < LIMIT;
  wire             wr_z   = ZERO_WORD && (wr_addr == '0);
  wire             rd_z   = ZERO_WORD && (rd_addr == '0);
  wire             wr_hit = wr_en && wr_in && !wr_z;
  wire [WIDTH-1:0] rd_word = (rd_in && !rd_z) ? mem[rd_addr] : '0;

  always_ff @(posedge clk)
    if (wr_hit) mem[wr_addr] <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> mem[$past(wr_addr)] == $past(src_sel ? wr_data_b : wr_data_a));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  assert_old_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_hit && rd_addr == wr_addr) |=> rd_data == $past(mem[rd_addr]));

  assert_zero_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ZERO_WORD && rd_addr == '0) |=> rd_data == '0);

  assert_oob_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && {1'b0, rd_addr} >= LIMIT) |=> rd_data == '0);

endmodule

// File: tb/sim_regfile_dualsrc.sv
`timescale 1ns/1ps
module sim_regfile_dualsrc;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0, re = 1'b0;
  logic [2:0] ra = '0, wa = '0;
  logic [31:0] da = '0, db = '0;
  logic [31:0] rd0, rd1;
  logic [31:0] m0 [8];
  logic [31:0] m1 [6];
  logic [31:0] e0 = '0, e1 = '0;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  regfile_dualsrc #(.WORDS(8), .WIDTH(32), .ZERO_WORD(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .src_sel(sel), .wr_en(we), .rd_en(re),
    .rd_addr(ra), .wr_addr(wa), .wr_data_a(da), .wr_data_b(db), .rd_data(rd0));

  regfile_dualsrc #(.WORDS(6), .WIDTH(32), .ZERO_WORD(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .src_sel(sel), .wr_en(we), .rd_en(re),
    .rd_addr(ra), .wr_addr(wa), .wr_data_a(da), .wr_data_b(db), .rd_data(rd1));

  // {sel, we, re, ra[2:0], wa[2:0], data_a[31:0]}; data_b = ~data_a
  localparam logic [40:0] VEC [9] = '{
    {1'b0, 1'b0, 1'b1, 3'd2, 3'd2, 32'hDEAD_0002},
    {1'b1, 1'b1, 1'b1, 3'd3, 3'd3, 32'h1111_0003},
    {1'b0, 1'b0, 1'b1, 3'd3, 3'd0, 32'h0000_0000},
    {1'b0, 1'b1, 1'b1, 3'd3, 3'd5, 32'h2222_0005},
    {1'b1, 1'b1, 1'b1, 3'd0, 3'd0, 32'h3333_0000},
    {1'b0, 1'b0, 1'b1, 3'd0, 3'd0, 32'h0000_0000},
    {1'b0, 1'b1, 1'b0, 3'd0, 3'd7, 32'h4444_0007},
    {1'b0, 1'b0, 1'b1, 3'd7, 3'd0, 32'h0000_0000},
    {1'b0, 1'b0, 1'b1, 3'd5, 3'd0, 32'h0000_0000}
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R3";
      1: return "R6";
      2: return "R4";
      3: return "R7";
      4: return "R8";
      5: return "R8";
      6: return "R9";
      7: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(logic s, logic w, logic r, logic [2:0] rad, logic [2:0] wad, logic [31:0] a);
    sel = s; we = w; re = r; ra = rad; wa = wad; da = a; db = ~a;
    @(posedge clk);
    if (r) begin
      e0 = m0[rad];
      e1 = (rad == 3'd0 || rad >= 3'd6) ? 32'h0 : m1[rad];
    end
    if (w) begin
      m0[wad] = s ? ~a : a;
      if (wad != 3'd0 && wad < 3'd6) m1[wad] = s ? ~a : a;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", rd0, 32'h0);
    check("R1", rd1, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      cyc(i[0], 1'b1, 1'b0, 3'd0, 3'(i), 32'hA000_0000 + i);
      check("R5 R1", rd0, 32'h0);
    end
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 1'b0, 1'b1, 3'(i), 3'd0, 32'h0);
      check("R2 R4", rd0, e0);
      check(i == 0 ? "R8" : (i >= 6 ? "R10" : "R2 R11"), rd1, e1);
    end
    for (int i = 0; i < 9; i++) begin
      cyc(VEC[i][40], VEC[i][39], VEC[i][38], VEC[i][37:35], VEC[i][34:32], VEC[i][31:0]);
      check(vtag(i), rd0, e0);
      check(vtag(i), rd1, e1);
    end
    cyc(1'b1, 1'b1, 1'b0, 3'd0, 3'd6, 32'h5555_0006);
    check("R5", rd0, e0);
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 1'b0, 1'b1, 3'(i), 3'd0, 32'h0);
      check("R3 R9", rd0, e0);
      check("R8 R9 R10", rd1, e1);
    end
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 5000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule